// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The block gathers interrupt events from twenty-one fixed sources. These are a power-on reset request, a watchdog underflow, four edge-sensed pins (two external interrupt lines and two counter inputs), six message-controller events, five timers and four serial-port events. Each maskable source has a request flag and an enable flag. The controller combines these with the CPU's global disable flag. It drives a single request line, together with the 16-bit vector address of the most urgent source that is pending.

When the CPU acknowledges, the controller latches the winning source and its vector. It clears that source's request flag and pulses a signal that tells the CPU to raise its disable flag. Software reaches the flags over a small byte-wide register bus. Software may clear request flags but can never set them. The reset and watchdog sources cannot be masked.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When reset is released, the reset source (index 0) is pending, so `irq_req` is 1 with `irq_vector` = 0xFFFA. All enable flags and all maskable request flags are 0, the four polarity bits are 1, and `ack_src`/`ack_vector` are 0.
- R2: A maskable source (index 2..20) contributes to `irq_req` only while its request flag is 1, its enable flag is 1 and `cpu_iflag` is 0. `cpu_iflag` acts combinationally.
- R3: Enable flags are 24 bits at bus addresses 3, 4, 5, where bit k of address 3+n is source 8n+k. A write sets or clears them as written. Bits for sources 0, 1 and 21..23 always read 0.
- R4: Request flags are read at addresses 0, 1, 2 with the same bit layout. Writing a 0 bit clears a maskable flag. Writing a 1 bit has no effect. Writes never alter the flags of sources 0 and 1.
- R5: Sources 0 (reset) and 1 (watchdog, `wdt_pulse`) raise `irq_req` whatever the enable flags and `cpu_iflag` are.
- R6: Among the pending sources, the lowest index wins. The indices are: 0 reset, 1 watchdog, 2 pin0, 3 pin1, 4..9 `msg_evt[0..5]`, 10..14 `tmr_evt[0..4]`, 15 pin2, 16 pin3, 17..20 `ser_evt[0..3]`.
- R7: The vector of source i is 0xFFFA − 2·i, which runs from 0xFFFA for reset down to 0xFFD2 for source 20.
- R8: When `irq_ack` is high on a clock edge while `irq_req` is high, that edge does three things. It loads `ack_src` and `ack_vector` with the winner, it clears the winner's request flag, and it drives `set_iflag` high for exactly the following cycle. `ack_src` and `ack_vector` hold until the next acknowledge.
- R9: Each `pin_in` bit passes through a two-flop synchroniser. Polarity bit p at address 6 (bit p for pin p) selects the active edge: 1 for rising, 0 for falling. The request is flagged on the third clock edge after the pin changes to its active level. A change to the inactive level sets nothing.
- R10: A polarity write that makes the present synchronised pin level active latches that pin's request on the next clock edge.
- R11: A one-cycle high pulse on `wdt_pulse`, `msg_evt`, `tmr_evt` or `ser_evt` sets the matching request flag at that clock edge. The flag stays set until it is acknowledged or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdt_pulse | input | 1 | Watchdog underflow pulse |
| msg_evt | input | 6 | Message-controller event pulses |
| tmr_evt | input | 5 | Timer underflow pulses |
| ser_evt | input | 4 | Serial-port event pulses |
| pin_in | input | 4 | Asynchronous edge-sensed pins |
| cpu_iflag | input | 1 | CPU global interrupt-disable flag |
| irq_ack | input | 1 | CPU acknowledge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vector | output | 16 | Vector address of current winner |
| ack_src | output | 5 | Index of the last acknowledged source |
| ack_vector | output | 16 | Vector latched at the last acknowledge |
| set_iflag | output | 1 | One-cycle request to raise the CPU disable flag |

## Verification
The single-pending case, with the enable flag off, then on, then gated by `cpu_iflag`, separates a faulty mask from a faulty latch. Three sources raised together and then drained by acknowledges check priority against index order. A higher-priority event arriving between acknowledges shows that the latched vector is frozen while the live vector moves on. Rising, falling and polarity-write stimuli on the pins distinguish the selected edge from the opposite one, and show the polarity-write side effect. Write patterns of all ones and of single zeros on the request bytes show that software can clear flags but not create them.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 21;
  localparam int IDXW  = $clog2(NSRC);
  localparam int NBYTE = (NSRC + 7) / 8;
  localparam int FLW   = NBYTE * 8;
  localparam int ADDRW = 3;
  localparam int NPIN  = 4;
  localparam logic [15:0] VEC_TOP = 16'hFFFA;

  // Vector address for a source index: pairs step down by two bytes.
  function automatic logic [15:0] vec_of(input logic [IDXW-1:0] idx);
    return VEC_TOP - {{(15-IDXW){1'b0}}, idx, 1'b0};
  endfunction

  // Lowest set index wins.
  function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (v[k]) r = k[IDXW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int NPIN   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin,
  input  logic [NPIN-1:0] pol,
  output logic [NPIN-1:0] hit
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] sh;
    logic              act_prev;
    logic              act;
    assign act = pol[p] ? sh[STAGES-1] : ~sh[STAGES-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh       <= '0;
        act_prev <= 1'b0;
      end else begin
        sh       <= {sh[STAGES-2:0], pin[p]};
        act_prev <= act;
      end
    end

    assign hit[p] = act & ~act_prev;

    // a detected edge is never reported on two cycles running
    assert_hit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[p] |=> !hit[p]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic            valid,
  output logic [IDXW-1:0] idx,
  output logic [15:0]     vector
);
  assign valid  = |pend;
  assign idx    = first_set(pend);
  assign vector = vec_of(idx);

  assert_win_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> pend[idx]);
  assert_win_highest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((pend & ((NSRC'(1) << idx) - NSRC'(1))) == '0));
  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (!vector[0] && vector >= 16'hFFD2 && vector <= VEC_TOP));
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  hw_set,
  input  logic             grant,
  input  logic [IDXW-1:0]  grant_idx,
  input  logic             bus_wr,
  input  logic [ADDRW-1:0] bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [NSRC-1:0]  req_q,
  output logic [NSRC-1:0]  en_q,
  output logic [NPIN-1:0]  pol_q,
  output logic [7:0]       bus_rdata
);
  localparam logic [FLW-1:0] MSK = ((FLW'(1) << NSRC) - FLW'(1)) & ~FLW'(3);
  localparam logic [ADDRW-1:0] POL_ADDR = ADDRW'(2 * NBYTE);

  logic [FLW-1:0] req_w, en_w, sw_clr, en_nx, ack_clr, req_nx;
  assign req_w = FLW'(req_q);
  assign en_w  = FLW'(en_q);

  always_comb begin
    sw_clr = '0;
    en_nx  = en_w;
    for (int b = 0; b < NBYTE; b++) begin
      if (bus_wr && bus_addr == ADDRW'(b))         sw_clr[b*8 +: 8] = ~bus_wdata;
      if (bus_wr && bus_addr == ADDRW'(NBYTE + b)) en_nx[b*8 +: 8]  = bus_wdata;
    end
    ack_clr = grant ? (FLW'(1) << grant_idx) : '0;
    req_nx  = (req_w & ~((sw_clr & MSK) | ack_clr)) | FLW'(hw_set);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= NSRC'(1);
      en_q  <= '0;
      pol_q <= '1;
    end else begin
      req_q <= req_nx[NSRC-1:0];
      en_q  <= en_nx[NSRC-1:0] & MSK[NSRC-1:0];
      if (bus_wr && bus_addr == POL_ADDR) pol_q <= bus_wdata[NPIN-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBYTE; b++) begin
      if (bus_addr == ADDRW'(b))         bus_rdata = req_w[b*8 +: 8];
      if (bus_addr == ADDRW'(NBYTE + b)) bus_rdata = en_w[b*8 +: 8];
    end
    if (bus_addr == POL_ADDR) bus_rdata = 8'(pol_q);
  end

  // flags only rise from hardware events
  assert_sw_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set == '0) |=> ((req_q & ~$past(req_q)) == '0));
  // non-maskable flags untouched by bus writes
  assert_nmi_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !grant && !hw_set[1]) |=> (req_q[1:0] == $past(req_q[1:0])));
  assert_en_nmi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[1:0] == 2'b00);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wdt_pulse,
  input  logic [5:0]  msg_evt,
  input  logic [4:0]  tmr_evt,
  input  logic [3:0]  ser_evt,
  input  logic [3:0]  pin_in,
  input  logic        cpu_iflag,
  input  logic        irq_ack,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq_req,
  output logic [15:0] irq_vector,
  output logic [4:0]  ack_src,
  output logic [15:0] ack_vector,
  output logic        set_iflag
);
  localparam logic [NSRC-1:0] NMI_MASK = NSRC'(3);

  logic [NPIN-1:0] pin_hit, pol_q;
  logic [NSRC-1:0] hw_set, req_q, en_q, pend;
  logic [IDXW-1:0] win_idx;
  logic [15:0]     win_vec;
  logic            win_valid, grant;

  assign hw_set = {ser_evt, pin_hit[3], pin_hit[2], tmr_evt, msg_evt,
                   pin_hit[1], pin_hit[0], wdt_pulse, 1'b0};

  irq_edge_sync #(.NPIN(NPIN), .STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .pol(pol_q), .hit(pin_hit));

  irq_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .grant(grant),
    .grant_idx(win_idx), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .req_q(req_q), .en_q(en_q), .pol_q(pol_q),
    .bus_rdata(bus_rdata));

  assign pend = (req_q & NMI_MASK) | (req_q & en_q & {NSRC{~cpu_iflag}});

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .valid(win_valid),
    .idx(win_idx), .vector(win_vec));

  assign irq_req    = win_valid;
  assign irq_vector = win_vec;
  assign grant      = irq_ack & win_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_src    <= '0;
      ack_vector <= '0;
      set_iflag  <= 1'b0;
    end else begin
      set_iflag <= grant;
      if (grant) begin
        ack_src    <= win_idx;
        ack_vector <= win_vec;
      end
    end
  end

  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (req_q[1:0] == 2'b00)) |-> !cpu_iflag);
  assert_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[1:0] != 2'b00) |-> irq_req);
  assert_ack_iflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> set_iflag);
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && irq_req) |=> ($stable(ack_vector) && !set_iflag));
  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !hw_set[win_idx]) |=> !req_q[$past(win_idx)]);
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_pulse = 1'b0;
  logic [5:0]  msg_evt = '0;
  logic [4:0]  tmr_evt = '0;
  logic [3:0]  ser_evt = '0;
  logic [3:0]  pin_in = '0;
  logic        cpu_iflag = 1'b0;
  logic        irq_ack = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic [4:0]  ack_src;
  logic [15:0] ack_vector;
  logic        set_iflag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_vec_ctrl uut (.*);

  always #5 clk = ~clk;

  function automatic logic [15:0] exp_vec(input int i);
    return 16'hFFFA - 16'(i * 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic req_chk(input bit r, input int src, input string tag);
    chk(irq_req == r, tag, irq_req, r);
    if (r) chk(irq_vector == exp_vec(src), tag, irq_vector, exp_vec(src));
  endtask

  task automatic ack_chk(input int src, input string tag);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    chk(ack_src == 5'(src), tag, ack_src, src);
    chk(ack_vector == exp_vec(src), tag, ack_vector, exp_vec(src));
    chk(set_iflag == 1'b1, tag, set_iflag, 1);
  endtask

  task automatic t_reset;
    req_chk(1'b1, 0, "R1 reset pending");
    rd_chk(3'd0, 8'h01, "R1 req byte0");
    rd_chk(3'd3, 8'h00, "R1 enable byte0");
    rd_chk(3'd6, 8'h0F, "R1 polarity");
    chk(ack_vector == 16'h0, "R1 ack_vector", ack_vector, 0);
    ack_chk(0, "R8 ack reset");
    req_chk(1'b0, 0, "R8 reset flag cleared");
    tick();
    chk(set_iflag == 1'b0, "R8 set_iflag one cycle", set_iflag, 0);
  endtask

  task automatic t_mask;
    tmr_evt[0] = 1'b1; tick(); tmr_evt[0] = 1'b0;
    rd_chk(3'd1, 8'h04, "R11 timer flag latched");
    req_chk(1'b0, 0, "R2 disabled source silent");
    wr(3'd4, 8'h04);
    req_chk(1'b1, 10, "R2 enabled source raises");
    cpu_iflag = 1'b1; #1;
    req_chk(1'b0, 0, "R2 global disable masks");
    cpu_iflag = 1'b0; #1;
  endtask

  task automatic t_req_write;
    wr(3'd1, 8'hFF);
    rd_chk(3'd1, 8'h04, "R4 write one keeps flag");
    wr(3'd2, 8'hFF);
    rd_chk(3'd2, 8'h00, "R4 write one cannot set");
    wr(3'd1, 8'hFB);
    rd_chk(3'd1, 8'h00, "R4 write zero clears");
    req_chk(1'b0, 0, "R4 cleared flag no request");
  endtask

  task automatic t_nmi;
    cpu_iflag = 1'b1;
    wdt_pulse = 1'b1; tick(); wdt_pulse = 1'b0;
    req_chk(1'b1, 1, "R5 watchdog ignores masks");
    wr(3'd0, 8'h00);
    rd_chk(3'd0, 8'h02, "R4 nmi flag write-protected");
    ack_chk(1, "R8 ack watchdog");
    req_chk(1'b0, 0, "R8 watchdog cleared");
    cpu_iflag = 1'b0;
  endtask

  task automatic t_enable;
    wr(3'd3, 8'hFF);
    rd_chk(3'd3, 8'hFC, "R3 enable byte0 readback");
    wr(3'd5, 8'hFF);
    rd_chk(3'd5, 8'h1F, "R3 enable byte2 readback");
    wr(3'd5, 8'h00);
    rd_chk(3'd5, 8'h00, "R3 enable clear");
    wr(3'd5, 8'h1F);
    wr(3'd4, 8'hFF);
  endtask

  task automatic t_priority;
    ser_evt[3] = 1'b1; tick(); ser_evt[3] = 1'b0;
    req_chk(1'b1, 20, "R7 lowest vector");
    msg_evt[0] = 1'b1; tmr_evt[4] = 1'b1; tick();
    msg_evt[0] = 1'b0; tmr_evt[4] = 1'b0;
    req_chk(1'b1, 4, "R6 message event wins");
    ack_chk(4, "R6 ack first winner");
    msg_evt[1] = 1'b1; tick(); msg_evt[1] = 1'b0;
    req_chk(1'b1, 5, "R6 late higher source");
    chk(ack_vector == exp_vec(4), "R8 ack vector held", ack_vector, exp_vec(4));
    ack_chk(5, "R6 ack second");
    ack_chk(14, "R6 ack timer");
    ack_chk(20, "R6 ack serial");
    req_chk(1'b0, 0, "R8 all drained");
  endtask

  task automatic t_edges;
    pin_in[0] = 1'b1; tick(2);
    rd_chk(3'd0, 8'h00, "R9 synchroniser latency");
    tick();
    rd_chk(3'd0, 8'h04, "R9 rising edge latched");
    req_chk(1'b1, 2, "R9 pin0 vector");
    wr(3'd0, 8'hFB);
    pin_in[0] = 1'b0; tick(4);
    rd_chk(3'd0, 8'h00, "R9 opposite edge ignored");
    wr(3'd6, 8'h0D);
    tick();
    rd_chk(3'd0, 8'h08, "R10 polarity write latches");
    wr(3'd0, 8'hF7);
    pin_in[1] = 1'b1; tick(4);
    rd_chk(3'd0, 8'h00, "R9 rising ignored when falling selected");
    pin_in[1] = 1'b0; tick(4);
    rd_chk(3'd0, 8'h08, "R9 falling edge latched");
    wr(3'd0, 8'hF7);
    pin_in[3] = 1'b1; tick(4);
    rd_chk(3'd2, 8'h01, "R9 pin3 index 16");
    pin_in[2] = 1'b1; tick(4);
    rd_chk(3'd1, 8'h80, "R9 pin2 index 15");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_req_write();
    t_nmi();
    t_enable();
    t_priority();
    t_edges();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule